// File: doc/BRIEF.md
# Byte-Memory DMA Boot Engine

This block copies data between a byte-wide external memory and on-chip word memory. Going inward, it gathers consecutive bytes into 24-bit program words or 16-bit data words and writes each finished word in a single cycle. Going outward, it reads one word and sends its bytes out one at a time. A transfer starts when software writes a nonzero word count. It runs until that count reaches zero. Every byte access is stretched by a programmable number of wait states. When the processor needs the external bus, the byte access stalls and the processor goes first.

After reset, if both mode-select pins are low, the block sets up a preset transfer and starts it. The preset loads the first 32 program words from external address 0 into on-chip address 0, and the processor is held until those words are in place. A context-reset control bit, which software can also set, holds the processor for the whole transfer. When the transfer ends, the hold is released and a restart pulse is sent so the processor resumes at address 0.

Top module: `bdma_boot_engine`

## Requirements
- R1: Writing a nonzero value to register 4 (word count) while idle starts a transfer of exactly that many words, after which the block goes idle. Writing zero starts nothing and leaves `xm_req_o` low.
- R2: Each byte access keeps `xm_req_o` high for (wait + 1) granted cycles. The wait value is register 3, bits [2:0], and its value after reset is BOOT_WAIT.
- R3: While `cpu_ext_req_i` is high, `xm_req_o` is low and the byte access in progress does not advance.
- R4: Inward transfers (control bit 0 = 0) work as follows. Control bit 1 = 0 builds a 24-bit word from 3 bytes, and control bit 1 = 1 builds a 16-bit word (zero-extended on `mem_wdata_o`) from 2 bytes. The first byte is the most significant. Each word is written with a one-cycle `mem_we_o` pulse. `mem_pm_o` is the inverse of control bit 1.
- R5: Outward transfers (control bit 0 = 1) start each word with a one-cycle `mem_re_o`. The word's bytes are then driven most significant first on `xm_wdata_o`, with `xm_we_o` high together with `xm_req_o`.
- R6: The on-chip address (register 1) increments once per word. The external address (register 2) increments once per byte and wraps within 14 bits. `xm_addr_o` is {page (control bits [15:8]), external address}.
- R7: `cpu_hold_o` is high during a transfer only if control bit 2 is set. It drops in the same cycle that `done_o` rises. `cpu_restart_o` then pulses for the single following cycle.
- R8: If `mode_sel_i` is 2'b00 when reset is released, the block holds the processor from reset. It then transfers 32 program words (24-bit, inward) from external address 0 to on-chip address 0, with the hold bit set. Any other mode leaves the block idle with no hold.
- R9: Register writes made while a transfer is running are ignored.
- R10: `done_o` rises when the count reaches zero, stays high while idle, and is cleared when the next transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_sel_i | input | 2 | Boot mode pins; 2'b00 selects the boot preset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index (0 control, 1 on-chip addr, 2 ext addr, 3 wait, 4 count) |
| reg_wdata_i | input | 16 | Register write data |
| cpu_ext_req_i | input | 1 | Processor is using the external bus |
| xm_req_o | output | 1 | Byte access cycle active on the external bus |
| xm_we_o | output | 1 | Byte access is a write |
| xm_addr_o | output | 22 | External byte address {page, address} |
| xm_wdata_o | output | 8 | Byte write data |
| xm_rdata_i | input | 8 | Byte read data |
| mem_we_o | output | 1 | On-chip word write |
| mem_re_o | output | 1 | On-chip word read |
| mem_pm_o | output | 1 | Access targets program memory (24-bit) |
| mem_addr_o | output | 14 | On-chip word address |
| mem_wdata_o | output | 24 | On-chip write word |
| mem_rdata_i | input | 24 | On-chip read word (combinational) |
| cpu_hold_o | output | 1 | Hold processor execution |
| cpu_restart_o | output | 1 | One-cycle restart-at-zero pulse |
| done_o | output | 1 | Transfer complete |

## Verification
A wrong byte index or wait counter shows up at the ports on the next word boundary. A word strobe lands a cycle early or late, or a word appears with its bytes in the wrong order or position, or `xm_addr_o` steps at the wrong moment. A wrong word count or busy state shows up on the last word. `done_o` and `cpu_hold_o` then change one or more words too early or too late, and `cpu_restart_o` appears or is missing in the cycle after. Because the reference model is compared against every output on every cycle, these faults are caught in the first cycle they become visible, not at the end of a transfer.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BYTE, ST_XFER} seq_state_e;
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_IADDR = 3'd1;
  localparam logic [2:0] RA_EADDR = 3'd2;
  localparam logic [2:0] RA_WAIT  = 3'd3;
  localparam logic [2:0] RA_COUNT = 3'd4;
  localparam int unsigned WORD_W  = 24;
endpackage

// File: rtl/bdma_regs.sv
module bdma_regs
  import bdma_pkg::*;
#(
  parameter int unsigned RW         = 16,
  parameter int unsigned IA_W       = 14,
  parameter int unsigned EA_W       = 14,
  parameter int unsigned PG_W       = 8,
  parameter int unsigned CNT_W      = 14,
  parameter int unsigned WS_W       = 3,
  parameter int unsigned BOOT_WORDS = 32,
  parameter int unsigned BOOT_WAIT  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_sel_i,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [RW-1:0]    wdata_i,
  input  logic             inc_ia_i,
  input  logic             inc_ea_i,
  input  logic             dec_cnt_i,
  output logic             dir_o,
  output logic             w16_o,
  output logic             ctx_o,
  output logic [PG_W-1:0]  page_o,
  output logic [IA_W-1:0]  ia_o,
  output logic [EA_W-1:0]  ea_o,
  output logic [WS_W-1:0]  wait_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             restart_o,
  output logic             boot_pend_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, restart_q, boot_pend_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign last_o       = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= 1'b0; w16_o <= 1'b0; ctx_o <= 1'b0; page_o <= '0;
      ia_o <= '0; ea_o <= '0; wait_o <= WS_W'(BOOT_WAIT); cnt_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; restart_q <= 1'b0; boot_pend_q <= 1'b1;
    end else begin
      restart_q <= 1'b0;
      if (boot_pend_q) begin
        boot_pend_q <= 1'b0;
        if (boot_sel_i) begin
          dir_o <= 1'b0; w16_o <= 1'b0; page_o <= '0; ia_o <= '0; ea_o <= '0;
          cnt_q <= CNT_W'(BOOT_WORDS); ctx_o <= 1'b1; busy_q <= 1'b1; done_q <= 1'b0;
        end
      end else if (we_i && !busy_q) begin
        case (addr_i)
          RA_CTRL: begin
            dir_o  <= wdata_i[0];
            w16_o  <= wdata_i[1];
            ctx_o  <= wdata_i[2];
            page_o <= wdata_i[8 +: PG_W];
          end
          RA_IADDR: ia_o   <= wdata_i[IA_W-1:0];
          RA_EADDR: ea_o   <= wdata_i[EA_W-1:0];
          RA_WAIT:  wait_o <= wdata_i[WS_W-1:0];
          RA_COUNT: begin
            cnt_q <= wdata_i[CNT_W-1:0];
            if (wdata_i[CNT_W-1:0] != '0) begin
              busy_q <= 1'b1;
              done_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (inc_ia_i) ia_o <= ia_o + IA_W'(1);
      if (inc_ea_i) ea_o <= ea_o + EA_W'(1);
      if (dec_cnt_i) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_o) begin
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          restart_q <= ctx_o;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign restart_o   = restart_q;
  assign boot_pend_o = boot_pend_q;

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q); // R10
  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !dec_cnt_i) |=> $stable(cnt_q)); // R9
  AST_RESTART_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |-> (!busy_q && $past(busy_q))); // R7
endmodule

// File: rtl/bdma_seq.sv
module bdma_seq
  import bdma_pkg::*;
#(
  parameter int unsigned WS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            busy_i,
  input  logic            dir_i,
  input  logic            w16_i,
  input  logic [WS_W-1:0] wait_i,
  input  logic            last_i,
  input  logic            cpu_req_i,
  output logic            xm_req_o,
  output logic            byte_done_o,
  output logic            word_wr_o,
  output logic            word_rd_o,
  output logic            dec_cnt_o,
  output logic            inc_ia_o,
  output logic            inc_ea_o
);
  seq_state_e      state_q;
  logic [WS_W-1:0] ws_q;
  logic [1:0]      idx_q;
  logic [1:0]      idx_end;
  logic            grant, word_end;

  assign idx_end     = w16_i ? 2'd1 : 2'd2;
  assign grant       = (state_q == ST_BYTE) && !cpu_req_i;
  assign byte_done_o = grant && (ws_q == wait_i);
  assign word_end    = byte_done_o && (idx_q == idx_end);
  assign xm_req_o    = grant;
  assign word_wr_o   = (state_q == ST_XFER) && !dir_i;
  assign word_rd_o   = (state_q == ST_XFER) && dir_i;
  assign dec_cnt_o   = word_wr_o || (word_end && dir_i);
  assign inc_ia_o    = (state_q == ST_XFER);
  assign inc_ea_o    = byte_done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ws_q    <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (busy_i) begin
          state_q <= dir_i ? ST_XFER : ST_BYTE;
          ws_q    <= '0;
          idx_q   <= '0;
        end
        ST_BYTE: if (grant) begin
          if (ws_q == wait_i) begin
            ws_q <= '0;
            if (idx_q == idx_end) begin
              idx_q <= '0;
              if (!dir_i)      state_q <= ST_XFER;
              else if (last_i) state_q <= ST_IDLE;
              else             state_q <= ST_XFER;
            end else begin
              idx_q <= idx_q + 2'd1;
            end
          end else begin
            ws_q <= ws_q + WS_W'(1);
          end
        end
        ST_XFER: begin
          if (!dir_i && last_i) state_q <= ST_IDLE;
          else                  state_q <= ST_BYTE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BYTE && cpu_req_i) |=> (state_q == ST_BYTE && $stable(ws_q) && $stable(idx_q))); // R3
  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BYTE) |-> (ws_q <= wait_i)); // R2
endmodule

// File: rtl/bdma_pack.sv
module bdma_pack
  import bdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              w16_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  input  logic [7:0]        byte_i,
  output logic [7:0]        byte_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= w16_i ? {word_i[15:0], 8'h00} : word_i;
    else if (shift_i) sh_q <= {sh_q[WORD_W-9:0], byte_i};
  end

  assign byte_o = sh_q[WORD_W-1 -: 8];
  assign word_o = w16_i ? {8'h00, sh_q[15:0]} : sh_q;
endmodule

// File: rtl/bdma_boot_engine.sv
module bdma_boot_engine
  import bdma_pkg::*;
#(
  parameter int unsigned IA_W       = 14,
  parameter int unsigned EA_W       = 14,
  parameter int unsigned PG_W       = 8,
  parameter int unsigned CNT_W      = 14,
  parameter int unsigned WS_W       = 3,
  parameter int unsigned BOOT_WORDS = 32,
  parameter int unsigned BOOT_WAIT  = 3,
  localparam int unsigned XA_W      = PG_W + EA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_sel_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  input  logic              cpu_ext_req_i,
  output logic              xm_req_o,
  output logic              xm_we_o,
  output logic [XA_W-1:0]   xm_addr_o,
  output logic [7:0]        xm_wdata_o,
  input  logic [7:0]        xm_rdata_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic              mem_pm_o,
  output logic [IA_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              cpu_hold_o,
  output logic              cpu_restart_o,
  output logic              done_o
);
  logic            dir, w16, ctx, last, busy, boot_pend, boot_sel;
  logic [PG_W-1:0] page;
  logic [EA_W-1:0] ea;
  logic [WS_W-1:0] wait_cfg;
  logic            byte_done, dec_cnt, inc_ia, inc_ea;

  assign boot_sel = (mode_sel_i == 2'b00);

  bdma_regs #(
    .RW(16), .IA_W(IA_W), .EA_W(EA_W), .PG_W(PG_W), .CNT_W(CNT_W), .WS_W(WS_W),
    .BOOT_WORDS(BOOT_WORDS), .BOOT_WAIT(BOOT_WAIT)
  ) i_regs (
    .clk_i, .rst_ni, .boot_sel_i(boot_sel),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .inc_ia_i(inc_ia), .inc_ea_i(inc_ea), .dec_cnt_i(dec_cnt),
    .dir_o(dir), .w16_o(w16), .ctx_o(ctx), .page_o(page),
    .ia_o(mem_addr_o), .ea_o(ea), .wait_o(wait_cfg), .last_o(last),
    .busy_o(busy), .done_o(done_o), .restart_o(cpu_restart_o), .boot_pend_o(boot_pend)
  );

  bdma_seq #(.WS_W(WS_W)) i_seq (
    .clk_i, .rst_ni, .busy_i(busy), .dir_i(dir), .w16_i(w16), .wait_i(wait_cfg),
    .last_i(last), .cpu_req_i(cpu_ext_req_i), .xm_req_o(xm_req_o),
    .byte_done_o(byte_done), .word_wr_o(mem_we_o), .word_rd_o(mem_re_o),
    .dec_cnt_o(dec_cnt), .inc_ia_o(inc_ia), .inc_ea_o(inc_ea)
  );

  bdma_pack i_pack (
    .clk_i, .rst_ni, .w16_i(w16), .load_i(mem_re_o), .word_i(mem_rdata_i),
    .shift_i(byte_done), .byte_i(xm_rdata_i), .byte_o(xm_wdata_o), .word_o(mem_wdata_o)
  );

  assign xm_we_o    = xm_req_o && dir;
  assign xm_addr_o  = {page, ea};
  assign mem_pm_o   = !w16;
  assign cpu_hold_o = (busy && ctx) || (boot_pend && boot_sel);

  AST_WORD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R4
  AST_HOLD_OFF_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !cpu_hold_o); // R7
endmodule

// File: tb/test_bdma_boot_engine.sv
module test_bdma_boot_engine;
  localparam int CLK_PERIOD = 10;
  localparam int IA_W = 14, EA_W = 14, PG_W = 8, CNT_W = 14, WS_W = 3;
  localparam int BOOT_WORDS = 32, BOOT_WAIT = 3;
  localparam int EA_SPAN = 1 << EA_W, IA_SPAN = 1 << IA_W;

  logic clk_i = 0, rst_ni = 0;
  logic [1:0] mode_sel_i = 2'b00;
  logic reg_we_i = 0;
  logic [2:0] reg_addr_i = 0;
  logic [15:0] reg_wdata_i = 0;
  logic cpu_ext_req_i = 0;
  logic xm_req_o, xm_we_o, mem_we_o, mem_re_o, mem_pm_o, cpu_hold_o, cpu_restart_o, done_o;
  logic [PG_W+EA_W-1:0] xm_addr_o;
  logic [7:0] xm_wdata_o, xm_rdata_i;
  logic [IA_W-1:0] mem_addr_o;
  logic [23:0] mem_wdata_o, mem_rdata_i;

  function automatic logic [7:0] xbyte(input logic [PG_W+EA_W-1:0] a);
    return a[7:0] * 8'd37 + a[15:8] + {2'b00, a[21:16]} + 8'd11;
  endfunction
  function automatic logic [23:0] mword(input logic [IA_W-1:0] a);
    return {a[7:0] ^ 8'h5A, ~a[7:0], a[7:0] + 8'h03};
  endfunction

  assign xm_rdata_i  = xbyte(xm_addr_o);
  assign mem_rdata_i = mword(mem_addr_o);

  bdma_boot_engine #(.IA_W(IA_W), .EA_W(EA_W), .PG_W(PG_W), .CNT_W(CNT_W), .WS_W(WS_W),
    .BOOT_WORDS(BOOT_WORDS), .BOOT_WAIT(BOOT_WAIT)) i_bdma_boot_engine (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_err = 0, n_wr = 0, n_rd = 0, n_req = 0;
  logic [31:0] last_xaddr = 0, last_maddr = 0;
  bit saw_restart = 0;
  int req_mode = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // behavioural reference model
  int m_phase, m_ws, m_nb, m_cnt, m_ia, m_ea, m_page, m_wait, t_nb;
  bit m_busy, m_done, m_rst, m_bootp, m_dir, m_w16, m_ctx, t_ob, t_fin;
  logic [7:0] q[$];
  logic [23:0] t_w;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase = 0; m_ws = 0; m_nb = 0; m_cnt = 0; m_ia = 0; m_ea = 0; m_page = 0;
      m_wait = BOOT_WAIT; m_busy = 0; m_done = 0; m_rst = 0; m_bootp = 1;
      m_dir = 0; m_w16 = 0; m_ctx = 0; q.delete();
    end else begin
      t_ob = m_busy; t_fin = 0; t_nb = m_w16 ? 2 : 3;
      if (t_ob) begin
        case (m_phase)
          0: begin m_phase = m_dir ? 2 : 1; m_ws = 0; m_nb = 0; end
          1: if (!cpu_ext_req_i) begin
               if (m_ws == m_wait) begin
                 m_ws = 0;
                 if (!m_dir) q.push_back(xbyte((PG_W+EA_W)'((m_page << EA_W) | m_ea)));
                 else void'(q.pop_front());
                 m_ea = (m_ea + 1) % EA_SPAN;
                 m_nb++;
                 if (m_nb == t_nb) begin
                   m_nb = 0;
                   if (!m_dir) m_phase = 2;
                   else begin
                     m_cnt--;
                     if (m_cnt == 0) begin t_fin = 1; m_phase = 0; end else m_phase = 2;
                   end
                 end
               end else m_ws++;
             end
          default: begin
            if (!m_dir) begin
              q.delete(); m_cnt--;
              t_fin = (m_cnt == 0);
              m_phase = t_fin ? 0 : 1;
            end else begin
              t_w = mword(IA_W'(m_ia)); q.delete();
              if (!m_w16) q.push_back(t_w[23:16]);
              q.push_back(t_w[15:8]); q.push_back(t_w[7:0]);
              m_phase = 1;
            end
            m_ia = (m_ia + 1) % IA_SPAN;
          end
        endcase
      end
      m_rst = 0;
      if (t_fin) begin m_busy = 0; m_done = 1; m_rst = m_ctx; end
      if (m_bootp) begin
        m_bootp = 0;
        if (mode_sel_i == 2'b00) begin
          m_dir = 0; m_w16 = 0; m_page = 0; m_ia = 0; m_ea = 0;
          m_cnt = BOOT_WORDS; m_ctx = 1; m_busy = 1; m_done = 0;
        end
      end else if (reg_we_i && !t_ob) begin
        case (reg_addr_i)
          3'd0: begin m_dir = reg_wdata_i[0]; m_w16 = reg_wdata_i[1];
                      m_ctx = reg_wdata_i[2]; m_page = reg_wdata_i[15:8]; end
          3'd1: m_ia = reg_wdata_i[IA_W-1:0];
          3'd2: m_ea = reg_wdata_i[EA_W-1:0];
          3'd3: m_wait = reg_wdata_i[WS_W-1:0];
          3'd4: begin
            m_cnt = reg_wdata_i[CNT_W-1:0];
            if (m_cnt != 0) begin m_busy = 1; m_done = 0; end
          end
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison
  bit e_req, e_we, e_re, e_hold;
  logic [31:0] e_addr;
  logic [23:0] e_word;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      e_req = (m_phase == 1) && !cpu_ext_req_i;
      e_addr = (m_page << EA_W) | m_ea;
      e_we = (m_phase == 2) && !m_dir;
      e_re = (m_phase == 2) && m_dir;
      e_hold = (m_busy && m_ctx) || (m_bootp && mode_sel_i == 2'b00);
      chk(xm_req_o === e_req, "R2/R3", "xm_req", xm_req_o, e_req);
      chk(xm_addr_o === e_addr[PG_W+EA_W-1:0], "R6", "xm_addr", xm_addr_o, e_addr);
      chk(xm_we_o === (e_req && m_dir), "R5", "xm_we", xm_we_o, e_req && m_dir);
      if (e_req && m_dir && q.size() > 0) chk(xm_wdata_o === q[0], "R5", "xm_wdata", xm_wdata_o, q[0]);
      chk(mem_we_o === e_we, "R4", "mem_we", mem_we_o, e_we);
      chk(mem_re_o === e_re, "R5", "mem_re", mem_re_o, e_re);
      if (e_we || e_re) begin
        chk(mem_addr_o === IA_W'(m_ia), "R6", "mem_addr", mem_addr_o, m_ia);
        chk(mem_pm_o === !m_w16, "R4", "mem_pm", mem_pm_o, !m_w16);
      end
      if (e_we && q.size() == (m_w16 ? 2 : 3)) begin
        e_word = m_w16 ? {8'h00, q[0], q[1]} : {q[0], q[1], q[2]};
        chk(mem_wdata_o === e_word, "R4", "mem_wdata", mem_wdata_o, e_word);
      end
      chk(cpu_hold_o === e_hold, "R7", "cpu_hold", cpu_hold_o, e_hold);
      chk(cpu_restart_o === m_rst, "R7", "cpu_restart", cpu_restart_o, m_rst);
      chk(done_o === m_done, "R10", "done", done_o, m_done);
      if (mem_we_o) begin n_wr++; last_maddr = mem_addr_o; end
      if (mem_re_o) n_rd++;
      if (xm_req_o) begin n_req++; last_xaddr = xm_addr_o; end
      if (cpu_restart_o) saw_restart = 1;
    end
  end

  // processor bus activity
  logic [7:0] lfsr = 8'hA5;
  initial forever begin
    @(posedge clk_i); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cpu_ext_req_i = (req_mode == 2) || (req_mode == 1 && lfsr[0] && lfsr[2]);
  end

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk_i); #1;
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    do begin @(negedge clk_i); t++; end while (!done_o && t < 20000);
  endtask

  task automatic do_reset(input logic [1:0] mode);
    rst_ni = 0; mode_sel_i = mode; reg_we_i = 0;
    repeat (3) @(negedge clk_i);
    chk(done_o === 1'b0, "R10", "reset done", done_o, 0);
    chk(xm_req_o === 1'b0, "R2", "reset xm_req", xm_req_o, 0);
    chk(mem_we_o === 1'b0, "R4", "reset mem_we", mem_we_o, 0);
    chk(cpu_restart_o === 1'b0, "R7", "reset restart", cpu_restart_o, 0);
    chk(cpu_hold_o === (mode == 2'b00), "R8", "reset hold", cpu_hold_o, mode == 2'b00);
    @(posedge clk_i); #1 rst_ni = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    int w0, r0, q0;
    // R8 boot preset with bus contention
    req_mode = 1;
    do_reset(2'b00);
    wait_done();
    @(negedge clk_i);
    chk(n_wr == BOOT_WORDS, "R8", "boot word count", n_wr, BOOT_WORDS);
    chk(last_maddr == BOOT_WORDS - 1, "R6", "boot last on-chip addr", last_maddr, BOOT_WORDS - 1);
    chk(saw_restart, "R7", "boot restart pulse", saw_restart, 1);

    // R8 no boot in other modes
    req_mode = 0;
    do_reset(2'b10);
    w0 = n_wr; q0 = n_req;
    repeat (20) @(negedge clk_i);
    chk(n_req == q0 && n_wr == w0, "R8", "no boot activity", n_req - q0, 0);
    chk(cpu_hold_o === 1'b0, "R8", "no boot hold", cpu_hold_o, 0);

    // R4/R6 16-bit inward, no hold, address wrap, wait 0
    req_mode = 1; saw_restart = 0; w0 = n_wr;
    wr_reg(3'd0, 16'h1202);
    wr_reg(3'd1, 16'h0100);
    wr_reg(3'd2, 16'h3FFE);
    wr_reg(3'd3, 16'h0000);
    wr_reg(3'd4, 16'd5);
    wait_done();
    @(negedge clk_i);
    chk(n_wr - w0 == 5, "R1", "inward word count", n_wr - w0, 5);
    chk(last_maddr == 32'h104, "R6", "inward last on-chip addr", last_maddr, 32'h104);
    chk(last_xaddr == 32'h48007, "R6", "inward wrapped ext addr", last_xaddr, 32'h48007);
    chk(!saw_restart, "R7", "no restart without hold", saw_restart, 0);

    // R5/R9 24-bit outward with hold, write ignored mid-run
    saw_restart = 0; r0 = n_rd;
    wr_reg(3'd0, 16'h0505);
    wr_reg(3'd1, 16'h0020);
    wr_reg(3'd2, 16'h0010);
    wr_reg(3'd3, 16'h0002);
    wr_reg(3'd4, 16'd3);
    @(negedge clk_i);
    chk(cpu_hold_o === 1'b1, "R7", "hold during outward", cpu_hold_o, 1);
    chk(done_o === 1'b0, "R10", "done cleared at start", done_o, 0);
    repeat (4) @(negedge clk_i);
    wr_reg(3'd2, 16'h0200);
    wait_done();
    @(negedge clk_i);
    chk(n_rd - r0 == 3, "R5", "outward word reads", n_rd - r0, 3);
    chk(last_xaddr == 32'h14018, "R9", "ext addr unaffected by busy write", last_xaddr, 32'h14018);
    chk(saw_restart, "R7", "restart after held run", saw_restart, 1);

    // R1 zero count starts nothing
    q0 = n_req;
    wr_reg(3'd4, 16'd0);
    repeat (10) @(negedge clk_i);
    chk(n_req == q0, "R1", "zero count idle", n_req - q0, 0);
    chk(done_o === 1'b1, "R10", "done kept on zero write", done_o, 1);

    // R3 processor owns the bus for a long stretch
    req_mode = 0; w0 = n_wr;
    wr_reg(3'd0, 16'h0000);
    wr_reg(3'd3, 16'h0001);
    req_mode = 2;
    wr_reg(3'd4, 16'd2);
    q0 = n_req;
    repeat (40) @(negedge clk_i);
    chk(n_req == q0, "R3", "no byte access under processor", n_req - q0, 0);
    chk(n_wr == w0, "R3", "no word while stalled", n_wr - w0, 0);
    req_mode = 0;
    wait_done();
    @(negedge clk_i);
    chk(n_wr - w0 == 2, "R1", "word count after stall", n_wr - w0, 2);

    repeat (5) @(negedge clk_i);
    finish_sim();
  end
endmodule